// File: doc/BRIEF.md
# Banked Cartridge Memory Mapper

This block sits between an 8-bit CPU bus with a 16-bit address and the memories of a large game cartridge. It keeps three pieces of state: a latch that opens or closes the external RAM, a 9-bit ROM bank number, and a 4-bit RAM bank number. The CPU sets this state by writing into the low half of the address space, where writes never reach the ROM. The ROM bank number is loaded through two separate write ranges, one for its low byte and one for its top bit.

For a read, the block turns the CPU address into a physical ROM or RAM address and raises the matching chip select. The lower 16 KiB window always shows bank 0. The upper 16 KiB window shows the selected bank, and bank 0 may be selected there. The 8 KiB window at 0xA000 shows the selected RAM bank. When a read has no valid target, the block raises `fill_ff`, and the surrounding logic must then return 0xFF to the CPU. There are two such cases: RAM that is closed or not fitted, and a ROM bank beyond the fitted size.

All outputs are combinational from the current request and the registered state. The CPU bus is a plain strobe interface. A request is accepted in the cycle its strobe is high, and there is no back-pressure, so `bus_rd` and `bus_wr` are never stalled. The bus never asserts both strobes in the same cycle.

Top module: `banked_cart_mapper`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0 and the RAM is closed. A read at 0x4000 gives `rom_addr` = 0x4000, and a read at 0xA000 gives `fill_ff` = 1 with `ram_cs` = 0.
- R2: A write in 0x0000–0x1FFF opens the RAM when wdata[3:0] is 0xA, regardless of wdata[7:4]. Any other low nibble closes the RAM.
- R3: A write in 0x2000–0x2FFF loads bits 7:0 of the ROM bank from wdata and keeps bit 8.
- R4: A write in 0x3000–0x3FFF loads bit 8 of the ROM bank from wdata[0] and keeps bits 7:0.
- R5: ROM bank 0 is not remapped. With bank 0 selected, a read in 0x4000–0x7FFF gives `rom_addr` = addr[13:0].
- R6: Before it forms an address, the ROM bank is masked to clog2(ROM_BANKS) bits. A read in 0x4000–0x7FFF gives `rom_addr` = masked_bank*0x4000 + addr[13:0] with `rom_cs` = 1. If the masked bank is not below ROM_BANKS, the read instead gives `rom_cs` = 0 and `fill_ff` = 1.
- R7: A read in 0x0000–0x3FFF gives `rom_cs` = 1 and `rom_addr` = addr[13:0], whatever bank is selected.
- R8: A write in 0x4000–0x5FFF loads the RAM bank from wdata[3:0]. With the RAM open, an access in 0xA000–0xBFFF gives `ram_cs` = 1 and `ram_addr` = (ram_bank mod RAM_BANKS)*0x2000 + addr[12:0]. `ram_we` follows `bus_wr`.
- R9: With the RAM closed, or with HAS_RAM = 0, an access in 0xA000–0xBFFF keeps `ram_cs` and `ram_we` low. A read there gives `fill_ff` = 1.
- R10: Writes below 0x8000 never assert `rom_cs` or `ram_cs`. Writes in 0x6000–0x7FFF change no state.
- R11: Outputs answer the request in the same cycle. A register write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| rom_addr | output | ROM_AW | Physical ROM byte address |
| rom_cs | output | 1 | ROM chip select for a valid read |
| ram_addr | output | RAM_AW | Physical RAM byte address |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |
| fill_ff | output | 1 | The read must return 0xFF |

## Verification
The hardest states to reach from the ports are a ROM bank whose top bit is set while its low byte is arbitrary, and a bank that lands past the fitted ROM. Both need ordered writes to the two bank ranges. The stimulus reaches them with directed write pairs in both orders and then reads the switchable window after each write. A second instance, with 24 banks and no RAM, shows that masking drops high bank bits and that the RAM window stays silent even after an open command. A seeded stretch of mixed reads and writes then runs against a behavioural model and compares every cycle.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
  typedef enum logic [3:0] {
    WIN_NONE,
    WIN_RAM_GATE,
    WIN_BANK_LO,
    WIN_BANK_HI,
    WIN_RAM_BANK,
    WIN_SPARE,
    WIN_ROM_FIX,
    WIN_ROM_SW,
    WIN_XRAM
  } win_e;

  localparam int unsigned ROM_OFF_W = 14;
  localparam int unsigned RAM_OFF_W = 13;
  localparam int unsigned ROM_BANK_W = 9;
  localparam int unsigned RAM_BANK_W = 4;
endpackage

// File: rtl/bcm_decode.sv
module bcm_decode
  import bcm_pkg::*;
(
  input  logic [15:0] addr,
  input  logic        wr,
  input  logic        rd,
  output win_e        win
);
  always_comb begin
    win = WIN_NONE;
    if (wr) begin
      unique case (addr[15:12])
        4'h0, 4'h1: win = WIN_RAM_GATE;
        4'h2:       win = WIN_BANK_LO;
        4'h3:       win = WIN_BANK_HI;
        4'h4, 4'h5: win = WIN_RAM_BANK;
        4'h6, 4'h7: win = WIN_SPARE;
        4'hA, 4'hB: win = WIN_XRAM;
        default:    win = WIN_NONE;
      endcase
    end else if (rd) begin
      unique case (addr[15:13])
        3'b000, 3'b001: win = WIN_ROM_FIX;
        3'b010, 3'b011: win = WIN_ROM_SW;
        3'b101:         win = WIN_XRAM;
        default:        win = WIN_NONE;
      endcase
    end
  end
endmodule

// File: rtl/bcm_bank_regs.sv
module bcm_bank_regs
  import bcm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  win_e                  win,
  input  logic [7:0]            wdata,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  ram_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_bank <= ROM_BANK_W'(1);
      ram_bank <= '0;
      ram_en   <= 1'b0;
    end else begin
      unique case (win)
        WIN_RAM_GATE: ram_en <= (wdata[3:0] == 4'hA);
        WIN_BANK_LO:  rom_bank[7:0] <= wdata;
        WIN_BANK_HI:  rom_bank[8] <= wdata[0];
        WIN_RAM_BANK: ram_bank <= wdata[3:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bcm_rom_map.sv
module bcm_rom_map
  import bcm_pkg::*;
#(
  parameter int unsigned ROM_BANKS = 320,
  localparam int unsigned BW = $clog2(ROM_BANKS),
  localparam int unsigned AW = BW + ROM_OFF_W
) (
  input  win_e                  win,
  input  logic [ROM_OFF_W-1:0]  off,
  input  logic [ROM_BANK_W-1:0] bank,
  output logic                  rom_cs,
  output logic [AW-1:0]         rom_addr,
  output logic                  rom_void
);
  logic [BW-1:0] masked;
  logic          beyond;

  assign masked = bank[BW-1:0];

  generate
    if ((ROM_BANKS & (ROM_BANKS - 1)) == 0) begin : g_pow2
      assign beyond = 1'b0;
    end else begin : g_partial
      localparam logic [BW:0] LIMIT = (BW + 1)'(ROM_BANKS);
      assign beyond = ({1'b0, masked} >= LIMIT);
    end
  endgenerate

  always_comb begin
    rom_cs   = 1'b0;
    rom_void = 1'b0;
    rom_addr = {{BW{1'b0}}, off};
    if (win == WIN_ROM_FIX) begin
      rom_cs = 1'b1;
    end else if (win == WIN_ROM_SW) begin
      rom_addr = {masked, off};
      rom_cs   = !beyond;
      rom_void = beyond;
    end
  end
endmodule

// File: rtl/bcm_ram_map.sv
module bcm_ram_map
  import bcm_pkg::*;
#(
  parameter int unsigned RAM_BANKS = 16,
  parameter bit HAS_RAM = 1'b1,
  localparam int unsigned BW = $clog2(RAM_BANKS),
  localparam int unsigned AW = BW + RAM_OFF_W
) (
  input  win_e                  win,
  input  logic                  wr,
  input  logic [RAM_OFF_W-1:0]  off,
  input  logic [RAM_BANK_W-1:0] bank,
  input  logic                  ram_en,
  output logic                  ram_cs,
  output logic                  ram_we,
  output logic [AW-1:0]         ram_addr,
  output logic                  ram_void
);
  logic open_ok;
  logic hit;

  assign open_ok  = HAS_RAM && ram_en;
  assign hit      = (win == WIN_XRAM);
  assign ram_cs   = hit && open_ok;
  assign ram_we   = ram_cs && wr;
  assign ram_void = hit && !open_ok && !wr;
  assign ram_addr = {bank[BW-1:0], off};
endmodule

// File: rtl/banked_cart_mapper.sv
module banked_cart_mapper
  import bcm_pkg::*;
#(
  parameter int unsigned ROM_BANKS = 320,
  parameter int unsigned RAM_BANKS = 16,
  parameter bit HAS_RAM = 1'b1,
  localparam int unsigned ROM_AW = $clog2(ROM_BANKS) + ROM_OFF_W,
  localparam int unsigned RAM_AW = $clog2(RAM_BANKS) + RAM_OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_cs,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_cs,
  output logic              ram_we,
  output logic              fill_ff
);
  win_e                  win;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_BANK_W-1:0] ram_bank;
  logic                  ram_en;
  logic                  rom_void;
  logic                  ram_void;

  bcm_decode u_dec (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .win  (win)
  );

  bcm_bank_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .win      (win),
    .wdata    (bus_wdata),
    .rom_bank (rom_bank),
    .ram_bank (ram_bank),
    .ram_en   (ram_en)
  );

  bcm_rom_map #(.ROM_BANKS(ROM_BANKS)) u_rom (
    .win      (win),
    .off      (bus_addr[ROM_OFF_W-1:0]),
    .bank     (rom_bank),
    .rom_cs   (rom_cs),
    .rom_addr (rom_addr),
    .rom_void (rom_void)
  );

  bcm_ram_map #(.RAM_BANKS(RAM_BANKS), .HAS_RAM(HAS_RAM)) u_ram (
    .win      (win),
    .wr       (bus_wr),
    .off      (bus_addr[RAM_OFF_W-1:0]),
    .bank     (ram_bank),
    .ram_en   (ram_en),
    .ram_cs   (ram_cs),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .ram_void (ram_void)
  );

  assign fill_ff = rom_void || ram_void;
endmodule

// File: rtl/banked_cart_mapper_chk.sv
module banked_cart_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        bus_wr,
  input logic        rom_cs,
  input logic        ram_cs,
  input logic        ram_we,
  input logic        fill_ff,
  input logic [8:0]  rom_bank,
  input logic        ram_en
);
  a_r9_ram_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs |-> ram_en);

  a_r10_reg_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr[15]) |-> (!rom_cs && !ram_cs));

  a_r11_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr[15:13] == 3'b001) |=> $stable(rom_bank));

  a_r2_open_next: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:13] == 3'b000 && bus_wdata[3:0] == 4'hA) |=> ram_en);

  a_r6_valid_not_fill: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> !fill_ff);

  a_r8_we_is_write: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (bus_wr && ram_cs));
endmodule

bind banked_cart_mapper banked_cart_mapper_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .rom_cs    (rom_cs),
  .ram_cs    (ram_cs),
  .ram_we    (ram_we),
  .fill_ff   (fill_ff),
  .rom_bank  (rom_bank),
  .ram_en    (ram_en)
);

// File: tb/banked_cart_mapper_tb_top.sv
module banked_cart_mapper_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;

  logic [22:0] a_rom_addr;
  logic        a_rom_cs;
  logic [16:0] a_ram_addr;
  logic        a_ram_cs, a_ram_we, a_fill;

  logic [18:0] b_rom_addr;
  logic        b_rom_cs;
  logic [13:0] b_ram_addr;
  logic        b_ram_cs, b_ram_we, b_fill;

  int total = 0;
  int bad = 0;

  int m_rom_bank;
  int m_ram_bank;
  bit m_en;

  always #(CLK_PERIOD / 2) clk = ~clk;

  banked_cart_mapper #(.ROM_BANKS(320), .RAM_BANKS(16), .HAS_RAM(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .rom_addr(a_rom_addr), .rom_cs(a_rom_cs),
    .ram_addr(a_ram_addr), .ram_cs(a_ram_cs), .ram_we(a_ram_we), .fill_ff(a_fill)
  );

  banked_cart_mapper #(.ROM_BANKS(24), .RAM_BANKS(2), .HAS_RAM(1'b0)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .rom_addr(b_rom_addr), .rom_cs(b_rom_cs),
    .ram_addr(b_ram_addr), .ram_cs(b_ram_cs), .ram_we(b_ram_we), .fill_ff(b_fill)
  );

  task automatic judge(string tag, string who, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s addr=%h act=%h exp=%h", tag, who, bus_addr, act, exp);
    end
  endtask

  task automatic check_inst(string tag, string who, int banks, int bw, int rams,
                            bit has, int rcs, int raddr, int xcs, int xwe,
                            int xaddr, int fill);
    int a = int'(bus_addr);
    int e_rcs = 0, e_raddr = -1, e_xcs = 0, e_xwe = 0, e_xaddr = -1, e_fill = 0;
    int m;
    if (bus_rd) begin
      if (a < 'h4000) begin
        e_rcs = 1; e_raddr = a;
      end else if (a < 'h8000) begin
        m = m_rom_bank & ((1 << bw) - 1);
        if (m >= banks) e_fill = 1;
        else begin e_rcs = 1; e_raddr = m * 'h4000 + (a % 'h4000); end
      end else if (a >= 'hA000 && a < 'hC000) begin
        if (has && m_en) begin
          e_xcs = 1; e_xaddr = (m_ram_bank % rams) * 'h2000 + (a % 'h2000);
        end else e_fill = 1;
      end
    end else if (bus_wr && a >= 'hA000 && a < 'hC000 && has && m_en) begin
      e_xcs = 1; e_xwe = 1; e_xaddr = (m_ram_bank % rams) * 'h2000 + (a % 'h2000);
    end
    judge(tag, {who, " rom_cs"}, rcs, e_rcs);
    if (e_raddr >= 0) judge(tag, {who, " rom_addr"}, raddr, e_raddr);
    judge(tag, {who, " ram_cs"}, xcs, e_xcs);
    judge(tag, {who, " ram_we"}, xwe, e_xwe);
    if (e_xaddr >= 0) judge(tag, {who, " ram_addr"}, xaddr, e_xaddr);
    judge(tag, {who, " fill_ff"}, fill, e_fill);
  endtask

  task automatic step(string tag, bit wr, bit rd, logic [15:0] addr, logic [7:0] data);
    int a = int'(addr);
    int d = int'(data);
    bus_addr = addr; bus_wdata = data; bus_wr = wr; bus_rd = rd;
    #1;
    check_inst(tag, "big", 320, 9, 16, 1'b1, int'(a_rom_cs), int'(a_rom_addr),
               int'(a_ram_cs), int'(a_ram_we), int'(a_ram_addr), int'(a_fill));
    check_inst(tag, "small", 24, 5, 2, 1'b0, int'(b_rom_cs), int'(b_rom_addr),
               int'(b_ram_cs), int'(b_ram_we), int'(b_ram_addr), int'(b_fill));
    @(posedge clk);
    if (wr) begin
      if (a < 'h2000) m_en = ((d & 15) == 10);
      else if (a < 'h3000) m_rom_bank = (m_rom_bank & 256) | d;
      else if (a < 'h4000) m_rom_bank = (m_rom_bank & 255) | ((d & 1) << 8);
      else if (a < 'h6000) m_ram_bank = d & 15;
    end
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic rd(string tag, logic [15:0] addr);
    step(tag, 1'b0, 1'b1, addr, 8'h00);
  endtask

  task automatic wr(string tag, logic [15:0] addr, logic [7:0] data);
    step(tag, 1'b1, 1'b0, addr, data);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_rom_bank = 1; m_ram_bank = 0; m_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd("R1", 16'h4000);
    rd("R1", 16'hA000);
    wr("R10", 16'h6000, 8'h01);
    rd("R10", 16'h4001);
    wr("R2", 16'h0000, 8'h1A);
    rd("R2", 16'hA123);
    wr("R2", 16'h1FFF, 8'hA0);
    rd("R2", 16'hA000);
    wr("R9", 16'hA010, 8'h55);
    wr("R2", 16'h0400, 8'h0A);
    rd("R11", 16'hBFFF);
    wr("R3", 16'h2000, 8'h25);
    rd("R3", 16'h7FFF);
    wr("R4", 16'h3000, 8'h01);
    rd("R4", 16'h4ABC);
    wr("R3", 16'h2FFF, 8'h00);
    rd("R3", 16'h4000);
    wr("R5", 16'h3FFF, 8'h00);
    rd("R5", 16'h4ABC);
    wr("R4", 16'h3000, 8'hFE);
    rd("R4", 16'h5000);
    wr("R4", 16'h3000, 8'h03);
    wr("R6", 16'h2000, 8'h7F);
    rd("R6", 16'h6000);
    wr("R6", 16'h2000, 8'h50);
    rd("R6", 16'h6001);
    wr("R6", 16'h2000, 8'h3F);
    rd("R6", 16'h7000);
    rd("R7", 16'h1234);
    rd("R7", 16'h3FFF);
    wr("R8", 16'h4000, 8'hF7);
    rd("R8", 16'hB456);
    wr("R8", 16'hBFFF, 8'h99);
    wr("R10", 16'h7FFF, 8'hFF);
    rd("R10", 16'hA001);
    wr("R10", 16'h1000, 8'h00);
    wr("R9", 16'hA200, 8'h11);
    rd("R9", 16'hA200);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] ad;
      logic [7:0]  dt;
      bit          w;
      ad = 16'($urandom_range(0, 16'hFFFF));
      dt = 8'($urandom_range(0, 255));
      w  = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 3) == 0) dt[3:0] = 4'hA;
      step("R11", w, !w, ad, dt);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule